// File: doc/BRIEF.md
# Power-Down Request Filter Timer

This block decides when a function's request to enter a low-power state has lasted long enough for the device to act on it. Software supplies a 3-bit filter code. The code either turns the feature off, picks one of three fixed hold times measured in whole seconds, or asks for immediate recognition. The request must stay asserted for the whole hold time. If it is still present when the time runs out, the block raises a sticky power-management interrupt, and a clear pulse acknowledges that interrupt.

Seconds come from a prescaler that counts `CLKS_PER_SEC` clocks. The prescaler is held at zero while no count is running, so every window starts on a clean second boundary. A parameter can swap the prescaler for a registered external one-second strobe instead. While a qualified count is running the block drives a busy flag. The request level, the filter code and the clear are plain control levels and pulses, and there is no data stream.

Top module: `pdn_req_filter`

## Requirements
- R1: Filter code 3'b000 is the off setting. With it, `irq_o` never rises and `busy_o` stays low, even while the request is held. Switching to 000 during a count abandons the count in the next cycle.
- R2: Code 3'b001 sets a 4-second window. If the request is first sampled high at clock edge E0 and stays high, `irq_o` is high from edge E0 + 4*CLKS_PER_SEC onward.
- R3: Code 3'b010 sets a 129-second window. `irq_o` rises at edge E0 + 129*CLKS_PER_SEC.
- R4: Code 3'b011 sets a 518-second window. `irq_o` rises at edge E0 + 518*CLKS_PER_SEC.
- R5: Any code with bit 2 set (3'b1xx) recognises the request at once. `irq_o` is high after the same edge E0 that first samples the request.
- R6: If the request drops at any point inside a window, the count is discarded and no interrupt follows. A later assertion times a full window again from its own first edge.
- R7: If the code changes during a count, the count restarts from zero under the new code at the edge that sees the change.
- R8: `irq_o` is low after reset. Once high, it stays high until `irq_clr_i` is sampled high, and it is low from the edge after that.
- R9: If a new qualification and a clear are sampled at the same edge, the qualification wins and `irq_o` stays high.
- R10: One held request produces at most one interrupt. After it qualifies, the request must drop before another window can start, so clearing while the request is still held leaves `irq_o` low.
- R11: `busy_o` is high exactly while a timed window is running. It is low when idle, when the feature is off, and from the edge on which the interrupt fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req_i | input | 1 | Power-down request level from the function |
| filt_code_i | input | 3 | Filter code: 000 off, 001/010/011 timed, 1xx immediate |
| sec_tick_i | input | 1 | One-cycle seconds strobe, used only when EXT_TICK = 1 |
| irq_clr_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Sticky power-management interrupt |
| busy_o | output | 1 | High while a timed window is counting |

## Verification
Two functions can fall in the same cycle: the event that sets the interrupt and the acknowledge that clears it. The bench provokes this by leaving an interrupt pending and letting the request fall. It then raises the request under an immediate code in the same cycle as a clear pulse, and `irq_o` must still be high afterwards. A second collision is a code change that lands inside a running window. The bench judges it by the exact edge at which the interrupt rises: that edge must be counted from the change, not from the original start.

// File: rtl/pdn_filt_pkg.sv
package pdn_filt_pkg;

  typedef enum logic [1:0] {
    PF_OFF,
    PF_TIMED,
    PF_NOW
  } pf_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COUNT,
    ST_HELD
  } pf_state_e;

  function automatic pf_kind_e pf_kind(input logic [2:0] code);
    if (code[2])              return PF_NOW;
    else if (code[1:0] == 2'b00) return PF_OFF;
    else                      return PF_TIMED;
  endfunction

endpackage

// File: rtl/pdn_sec_base.sv
module pdn_sec_base #(
  parameter int CLKS_PER_SEC = 10,
  parameter bit EXT_TICK     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ext_tick_i,
  output logic sec_tick_o
);

  localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;

  generate
    if (EXT_TICK) begin : g_ext
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= ext_tick_i;
      end
      assign sec_tick_o = run_i && tick_q;
    end else begin : g_presc
      logic [PW-1:0] presc_q;
      logic          wrap;
      logic          unused_ext;
      assign unused_ext = ext_tick_i;
      assign wrap       = (presc_q == PW'(CLKS_PER_SEC - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      presc_q <= '0;
        else if (!run_i) presc_q <= '0;
        else if (wrap)   presc_q <= '0;
        else             presc_q <= presc_q + 1'b1;
      end
      assign sec_tick_o = run_i && wrap;
    end
  endgenerate

endmodule

// File: rtl/pdn_window_ctl.sv
module pdn_window_ctl
  import pdn_filt_pkg::*;
#(
  parameter int DLY_A = 4,
  parameter int DLY_B = 129,
  parameter int DLY_C = 518
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [2:0] code_i,
  input  logic       sec_tick_i,
  output logic       run_o,
  output logic       counting_o,
  output logic       fire_o
);

  localparam int SW = $clog2(DLY_C + 1);

  pf_state_e     state_q, state_d;
  logic [2:0]    code_q;
  logic [SW-1:0] sec_q;
  logic [SW-1:0] tgt;
  logic          restart;
  logic          load;
  pf_kind_e      kind;

  assign kind = pf_kind(code_i);

  always_comb begin
    case (code_i[1:0])
      2'b01:   tgt = SW'(DLY_A);
      2'b10:   tgt = SW'(DLY_B);
      2'b11:   tgt = SW'(DLY_C);
      default: tgt = SW'(1);
    endcase
  end

  assign restart = (state_q == ST_IDLE) ||
                   ((state_q == ST_COUNT) && (code_i != code_q));

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    load    = 1'b0;
    if (restart) begin
      if (req_i && kind == PF_NOW) begin
        fire_o  = 1'b1;
        state_d = ST_HELD;
      end else if (req_i && kind == PF_TIMED) begin
        load    = 1'b1;
        state_d = ST_COUNT;
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      case (state_q)
        ST_COUNT: begin
          if (!req_i) begin
            state_d = ST_IDLE;
          end else if (sec_tick_i && sec_q == tgt - 1'b1) begin
            fire_o  = 1'b1;
            state_d = ST_HELD;
          end
        end
        ST_HELD: if (!req_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= 3'b000;
      sec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        code_q <= code_i;
        sec_q  <= '0;
      end else if (state_q == ST_COUNT && sec_tick_i) begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  assign counting_o = (state_q == ST_COUNT);
  assign run_o      = (state_q == ST_COUNT) && !restart && req_i;

endmodule

// File: rtl/pdn_irq_latch.sv
module pdn_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

endmodule

// File: rtl/pdn_req_filter.sv
module pdn_req_filter #(
  parameter int CLKS_PER_SEC = 33_000_000,
  parameter bit EXT_TICK     = 1'b0,
  parameter int DLY_A        = 4,
  parameter int DLY_B        = 129,
  parameter int DLY_C        = 518
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req_i,
  input  logic [2:0] filt_code_i,
  input  logic       sec_tick_i,
  input  logic       irq_clr_i,
  output logic       irq_o,
  output logic       busy_o
);

  logic run;
  logic sec_tick;
  logic fire;

  pdn_sec_base #(
    .CLKS_PER_SEC(CLKS_PER_SEC),
    .EXT_TICK    (EXT_TICK)
  ) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .ext_tick_i(sec_tick_i),
    .sec_tick_o(sec_tick)
  );

  pdn_window_ctl #(
    .DLY_A(DLY_A),
    .DLY_B(DLY_B),
    .DLY_C(DLY_C)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (pd_req_i),
    .code_i    (filt_code_i),
    .sec_tick_i(sec_tick),
    .run_o     (run),
    .counting_o(busy_o),
    .fire_o    (fire)
  );

  pdn_irq_latch u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(fire),
    .clr_i(irq_clr_i),
    .irq_o(irq_o)
  );

endmodule

// File: rtl/pdn_req_filter_chk.sv
module pdn_req_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_req_i,
  input logic [2:0] filt_code_i,
  input logic       irq_clr_i,
  input logic       irq_o,
  input logic       busy_o
);

  // R1: off code never raises the interrupt
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_code_i == 3'b000 && !irq_o) |=> !irq_o);

  // R1: off code stops any count
  a_r1_off_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_code_i == 3'b000) |=> !busy_o);

  // R5 / R9: immediate code qualifies on the first edge, clear or not
  a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_req_i) && filt_code_i[2]) |=> irq_o);

  // R8: sticky until acknowledged
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R8: clear with no request present drops the interrupt
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_clr_i && !pd_req_i) |=> !irq_o);

  // R11: busy only while the request was held
  a_r11_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $past(pd_req_i));

  // R6: interrupt rises only with the request present at that edge
  a_r6_requalified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pd_req_i));

endmodule

bind pdn_req_filter pdn_req_filter_chk u_chk (.*);

// File: tb/tb_pdn_req_filter.sv
module tb_pdn_req_filter;

  localparam int CPS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_req_i = 1'b0;
  logic [2:0] filt_code_i = 3'b000;
  logic       sec_tick_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       irq_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  logic irq_prev = 1'b0;
  bit   mon_en = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pdn_req_filter #(.CLKS_PER_SEC(CPS)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req_i), .filt_code_i(filt_code_i),
    .sec_tick_i(sec_tick_i), .irq_clr_i(irq_clr_i), .irq_o(irq_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: raise the request and push the edge at which irq_o must rise
  task automatic raise_req(input logic [2:0] code, input int secs, input bit fires);
    filt_code_i = code;
    pd_req_i    = 1'b1;
    if (fires) exp_q.push_back(cyc + 1 + secs * CPS);
  endtask

  task automatic ack_and_drop();
    irq_clr_i = 1'b1;
    pd_req_i  = 1'b0;
    @(negedge clk);
    irq_clr_i = 1'b0;
    wait_n(2);
  endtask

  // monitor: every rise of irq_o is matched against the scoreboard
  always @(negedge clk) begin
    if (mon_en && irq_o && !irq_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected interrupt", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2-R7 interrupt edge", cyc, e);
      end
    end
    irq_prev = irq_o;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    chk(irq_o == 1'b0, "R8 reset irq", irq_o, 0);
    chk(busy_o == 1'b0, "R11 reset busy", busy_o, 0);

    // R1: off code, request held
    raise_req(3'b000, 0, 1'b0);
    wait_n(60);
    chk(irq_o == 1'b0, "R1 off irq", irq_o, 0);
    chk(busy_o == 1'b0, "R1 off busy", busy_o, 0);
    pd_req_i = 1'b0;
    wait_n(2);

    // R2 / R11 / R10 / R8: 4 second window
    raise_req(3'b001, 4, 1'b1);
    wait_n(20);
    chk(busy_o == 1'b1, "R11 busy mid window", busy_o, 1);
    wait_n(25);
    chk(busy_o == 1'b0, "R11 busy after fire", busy_o, 0);
    chk(irq_o == 1'b1, "R2 irq after window", irq_o, 1);
    wait_n(100);
    chk(irq_o == 1'b1, "R8 irq sticky", irq_o, 1);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
    chk(irq_o == 1'b0, "R8 cleared", irq_o, 0);
    wait_n(60);
    chk(irq_o == 1'b0, "R10 no refire while held", irq_o, 0);
    chk(busy_o == 1'b0, "R10 no new window while held", busy_o, 0);
    pd_req_i = 1'b0;
    wait_n(2);

    // R3: 129 seconds
    raise_req(3'b010, 129, 1'b1);
    wait_n(1300);
    chk(irq_o == 1'b1, "R3 irq", irq_o, 1);
    ack_and_drop();

    // R4: 518 seconds
    raise_req(3'b011, 518, 1'b1);
    wait_n(5190);
    chk(irq_o == 1'b1, "R4 irq", irq_o, 1);
    ack_and_drop();

    // R5: immediate codes
    raise_req(3'b100, 0, 1'b1);
    @(negedge clk);
    chk(irq_o == 1'b1, "R5 immediate 100", irq_o, 1);
    chk(busy_o == 1'b0, "R5 immediate not busy", busy_o, 0);
    ack_and_drop();
    raise_req(3'b111, 0, 1'b1);
    @(negedge clk);
    chk(irq_o == 1'b1, "R5 immediate 111", irq_o, 1);
    ack_and_drop();

    // R6: drop inside window, then full window again
    raise_req(3'b001, 4, 1'b0);
    wait_n(25);
    pd_req_i = 1'b0;
    wait_n(30);
    chk(irq_o == 1'b0, "R6 dropped no irq", irq_o, 0);
    chk(busy_o == 1'b0, "R6 dropped idle", busy_o, 0);
    raise_req(3'b001, 4, 1'b1);
    wait_n(39);
    chk(irq_o == 1'b0, "R6 not early", irq_o, 0);
    wait_n(2);
    chk(irq_o == 1'b1, "R6 full window", irq_o, 1);
    ack_and_drop();

    // R7: code change restarts under new code
    raise_req(3'b001, 4, 1'b0);
    wait_n(25);
    raise_req(3'b010, 129, 1'b1);
    wait_n(30);
    chk(irq_o == 1'b0, "R7 old window ignored", irq_o, 0);
    chk(busy_o == 1'b1, "R7 still counting", busy_o, 1);
    wait_n(1270);
    chk(irq_o == 1'b1, "R7 irq after new window", irq_o, 1);
    ack_and_drop();

    // R9: qualification and clear at the same edge
    raise_req(3'b100, 0, 1'b1);
    wait_n(2);
    pd_req_i = 1'b0;
    wait_n(3);
    chk(irq_o == 1'b1, "R8 pending after drop", irq_o, 1);
    pd_req_i  = 1'b1;
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
    chk(irq_o == 1'b1, "R9 set wins over clear", irq_o, 1);
    ack_and_drop();
    chk(irq_o == 1'b0, "R8 clear after collision", irq_o, 0);

    // R1: switch to off during count
    raise_req(3'b011, 0, 1'b0);
    wait_n(50);
    filt_code_i = 3'b000;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 off aborts count", busy_o, 0);
    wait_n(5200);
    chk(irq_o == 1'b0, "R1 off never fires", irq_o, 0);
    pd_req_i = 1'b0;
    wait_n(2);

    chk(exp_q.size() == 0, "R2-R7 pending expectations", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule